// File: doc/BRIEF.md
# Serial ID Responder

This block stands in for a small identification chip that a host drives by software. The host writes a 16-bit control word in which separate bits act as the chip's data, clock, reset, start and command lines. Moving those lines in software shifts out either a fixed 32-bit board identifier or single bytes of a stored serial-number image. The chip returns one bit per clock on a single data-out line.

Commands are clocked in serially while the command line is high. One command selects an 8-byte page of the serial image, and eight other commands each load one byte of that page into the output shift buffer. The serial image itself lives outside the block. The block shows a byte address on `img_addr` and takes the addressed byte from `img_byte` in the same cycle.

Top module: `serial_id_responder`

## Requirements
- R1: While `rst_n` is low, the block clears its shift state, bit position, shift buffer, command, last executed command, page and clock history. After reset, `dout` reads 0 and `img_addr` reads 0.
- R2: Control word fields are data in = bit 0, clock = bit 1, reset = bit 2, start = bit 3 and command mode = bit 4. Clock edges are found by comparing the clock bit with the clock bit of the previous accepted write. A cycle with `wr_en` low changes nothing, whatever `wr_data` holds.
- R3: On a clock falling edge in the idle state with start high, the block enters the load state. In the load state it puts 0x980055AA in the buffer and sets the position to 0. A falling edge in the load state with start low moves to the shift state, and that same edge already advances the position.
- R4: In the shift state, each falling edge adds one to the position. `dout` shows buffer bit (31 - position), so the buffer leaves most significant bit first.
- R5: The position stops at 32. While it is 32, `dout` is 0.
- R6: A write with the reset bit set puts the state in idle and the position at 0. It does not change the buffer. Within that write, this happens before any clock-edge handling.
- R7: A rising clock edge with command mode high shifts the 8-bit command left by one and puts data in as the new bit 0. A rising edge with command mode low leaves the command unchanged.
- R8: A command runs only on a falling clock edge where the command-mode level seen at the last edge was high and the new command bit is low. It also runs only if the command differs from the last one that ran. Dropping command mode without a clock edge runs nothing.
- R9: A command with bits 7 and 0 both set makes bits 6:1 the page number and clears the buffer and the position. It does not change the state.
- R10: Commands 0x55, 0xAA, 0x54, 0xA8, 0x50, 0xA0, 0x40 and 0x80 select offsets 0 through 7. `img_addr` = 8*page + offset; any other command gives offset 0. Running one of these commands puts `img_byte` in buffer bits 31:24 and zeros below it. It also sets the shift state and a position of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word (fields in R2) |
| img_byte | input | 8 | Serial image byte at `img_addr` |
| img_addr | output | 9 | Serial image byte address |
| dout | output | 1 | Current output bit |

## Verification
The bench builds the block with its default parameters: a 32-bit identifier, an 8-bit command and a 6-bit page. With these values a full identifier walk runs to the saturated position. Pages up to 63 are also in reach, and their addresses run past the 69-byte image, where the bench model returns zero. Every byte opcode is issued against one page. The bench also issues a repeated command, a command-mode drop with no clock edge, and a reset bit that arrives together with a falling edge.

// File: rtl/serial_id_responder.sv
`timescale 1ns/1ps
module serial_id_responder #(
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h980055AA,
  parameter int PAGE_W = 6,
  parameter int BYTE_W = 8,
  parameter int CTRL_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [CTRL_W-1:0]            wr_data,
  input  logic [BYTE_W-1:0]            img_byte,
  output logic [PAGE_W+$clog2(PAGE_W+2)-1:0] img_addr,
  output logic                         dout
);
  localparam int CMD_W = PAGE_W + 2;
  localparam int OFF_W = $clog2(CMD_W);
  localparam int POS_W = $clog2(ID_W + 1);
  localparam int IDX_W = $clog2(ID_W);
  localparam logic [POS_W-1:0] POS_END = POS_W'(ID_W);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} st_t;

  st_t                state_q, state_d;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic [ID_W-1:0]    buf_q, buf_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d, last_q, last_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic               prev_clk_q, cmd_mode_q, cmd_mode_d;

  wire din    = wr_data[0];
  wire clk_b  = wr_data[1];
  wire rst_b  = wr_data[2];
  wire sta_b  = wr_data[3];
  wire cmd_b  = wr_data[4];

  logic unused_hi;
  assign unused_hi = ^wr_data[CTRL_W-1:5];

  wire fall = wr_en & prev_clk_q & ~clk_b;
  wire rise = wr_en & ~prev_clk_q & clk_b;

  function automatic logic [CMD_W-1:0] op_pat(input int k);
    logic [CMD_W-1:0] base;
    base = k[0] ? {(CMD_W/2){2'b10}} : {(CMD_W/2){2'b01}};
    return base & ({CMD_W{1'b1}} << k);
  endfunction

  logic             op_hit;
  logic [OFF_W-1:0] op_off;
  always_comb begin
    op_hit = 1'b0;
    op_off = '0;
    for (int k = 0; k < CMD_W; k++) begin
      if (cmd_q == op_pat(k)) begin
        op_hit = 1'b1;
        op_off = OFF_W'(k);
      end
    end
  end

  wire page_hit = cmd_q[CMD_W-1] & cmd_q[0];
  wire run_cmd  = fall & cmd_mode_q & ~cmd_b & (cmd_q != last_q);

  assign img_addr = {page_q, op_off};

  always_comb begin
    state_d    = state_q;
    pos_d      = pos_q;
    buf_d      = buf_q;
    cmd_d      = cmd_q;
    last_d     = last_q;
    page_d     = page_q;
    cmd_mode_d = cmd_mode_q;
    if (wr_en && rst_b) begin
      state_d = ST_IDLE;
      pos_d   = '0;
    end
    if (fall) begin
      if (state_d == ST_IDLE && sta_b) state_d = ST_LOAD;
      if (state_d == ST_LOAD && !sta_b) state_d = ST_SHIFT;
      if (state_d == ST_LOAD) begin
        buf_d = ID_VALUE;
        pos_d = '0;
      end
      if (state_d == ST_SHIFT && pos_d < POS_END) pos_d = pos_d + POS_W'(1);
      if (run_cmd) begin
        if (page_hit) begin
          page_d = cmd_q[PAGE_W:1];
          buf_d  = '0;
          pos_d  = '0;
        end
        if (op_hit) begin
          state_d = ST_SHIFT;
          pos_d   = '0;
          buf_d   = {img_byte, {(ID_W-BYTE_W){1'b0}}};
        end
        last_d = cmd_q;
      end
      cmd_mode_d = cmd_b;
    end
    if (rise && cmd_b) begin
      cmd_d      = {cmd_q[CMD_W-2:0], din};
      cmd_mode_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pos_q      <= '0;
      buf_q      <= '0;
      cmd_q      <= '0;
      last_q     <= '0;
      page_q     <= '0;
      prev_clk_q <= 1'b0;
      cmd_mode_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pos_q      <= pos_d;
      buf_q      <= buf_d;
      cmd_q      <= cmd_d;
      last_q     <= last_d;
      page_q     <= page_d;
      cmd_mode_q <= cmd_mode_d;
      if (wr_en) prev_clk_q <= clk_b;
    end
  end

  wire [IDX_W-1:0] bit_idx = IDX_W'(ID_W-1) - pos_q[IDX_W-1:0];
  assign dout = (pos_q < POS_END) & buf_q[bit_idx];

endmodule

// File: rtl/serial_id_responder_chk.sv
`timescale 1ns/1ps
module serial_id_responder_chk #(
  parameter int ID_W = 32,
  parameter int PAGE_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [4:0]            ctl,
  input logic                  dout,
  input logic [1:0]            state_q,
  input logic [$clog2(ID_W+1)-1:0] pos_q,
  input logic [ID_W-1:0]       buf_q,
  input logic [PAGE_W+1:0]     cmd_q,
  input logic [PAGE_W+1:0]     last_q,
  input logic                  prev_clk_q,
  input logic                  cmd_mode_q
);
  localparam int CMD_W = PAGE_W + 2;
  localparam int POS_W = $clog2(ID_W + 1);
  localparam logic [POS_W-1:0] POS_END = POS_W'(ID_W);

  wire fall = wr_en & prev_clk_q & ~ctl[1];

  assert_pos_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_END);

  assert_out_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q == POS_END |-> !dout);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pos_q) && $stable(buf_q) && $stable(state_q) && $stable(cmd_q));

  assert_rst_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ctl[2] && !fall |=> state_q == 2'd0 && pos_q == '0);

  assert_cmd_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !prev_clk_q && ctl[1] && ctl[4] |=> cmd_q == {$past(cmd_q[CMD_W-2:0]), $past(ctl[0])});

  assert_repeat_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !ctl[2] && cmd_q == last_q && state_q == 2'd2 && pos_q < POS_END
    |=> pos_q == $past(pos_q) + POS_W'(1) && $stable(buf_q));

  assert_page_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fall && cmd_mode_q && !ctl[4] && cmd_q != last_q && cmd_q[CMD_W-1] && cmd_q[0]
    |=> buf_q == '0 && pos_q == '0 && !dout);

endmodule

bind serial_id_responder serial_id_responder_chk #(.ID_W(ID_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctl(wr_data[4:0]), .dout(dout),
  .state_q(state_q), .pos_q(pos_q), .buf_q(buf_q), .cmd_q(cmd_q), .last_q(last_q),
  .prev_clk_q(prev_clk_q), .cmd_mode_q(cmd_mode_q)
);

// File: tb/test_serial_id_responder.sv
`timescale 1ns/1ps
module test_serial_id_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [7:0]  img_byte;
  logic [8:0]  img_addr;
  logic        dout;

  localparam logic [31:0] ID = 32'h980055AA;
  localparam logic [7:0] OPS [8] = '{8'h55, 8'hAA, 8'h54, 8'hA8, 8'h50, 8'hA0, 8'h40, 8'h80};

  always #4 clk = ~clk;

  serial_id_responder i_serial_id_responder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .img_byte(img_byte), .img_addr(img_addr), .dout(dout)
  );

  function automatic logic [7:0] img_model(input logic [8:0] a);
    int v;
    v = int'(a) * 37 + 11;
    return (a < 9'd69) ? v[7:0] : 8'h00;
  endfunction

  assign img_byte = img_model(img_addr);

  typedef struct {
    bit         is_addr;
    logic [8:0] val;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [8:0] act;
      it = q.pop_front();
      act = it.is_addr ? img_addr : {8'b0, dout};
      total++;
      if (act !== it.val) begin
        bad++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.val);
      end
    end
  end

  function automatic logic [15:0] cw(bit d, bit c, bit r, bit s, bit m);
    return {11'b0, m, s, r, c, d};
  endfunction

  task automatic wr(input logic [15:0] w);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = w;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic exp_out(input logic v, input string tag);
    q.push_back('{1'b0, {8'b0, v}, tag});
  endtask

  task automatic exp_addr(input int a, input string tag);
    q.push_back('{1'b1, 9'(a), tag});
  endtask

  task automatic pulse(input bit s);
    wr(cw(0, 1, 0, s, 0));
    wr(cw(0, 0, 0, s, 0));
  endtask

  task automatic shift_cmd(input logic [7:0] c, input bit noisy);
    for (int i = 7; i >= 0; i--) begin
      wr(cw(c[i], 0, 0, 0, 1));
      wr(cw(c[i], 1, 0, 0, 1));
      if (noisy) begin
        wr(cw(0, 0, 0, 0, 1));
        wr(cw(1, 1, 0, 0, 0));
      end
    end
  endtask

  task automatic send_cmd(input logic [7:0] c, input bit noisy);
    shift_cmd(c, noisy);
    wr(cw(0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    exp_out(1'b0, "R1 dout after reset");
    exp_addr(0, "R1 img_addr after reset");

    wr_data = cw(0, 1, 0, 1, 0);
    repeat (3) @(posedge clk);
    #1 wr_data = cw(0, 0, 0, 1, 0);
    repeat (3) @(posedge clk);
    #1;
    exp_out(1'b0, "R2 toggles without wr_en ignored");
    wr(cw(0, 0, 0, 1, 0));
    wr(cw(0, 0, 0, 1, 0));
    exp_out(1'b0, "R2 same clock level is no edge");

    pulse(1'b1);
    exp_out(1'b1, "R3 identifier loaded");
    pulse(1'b1);
    exp_out(1'b1, "R3 load state holds position");
    pulse(1'b0);
    exp_out(ID[30], "R3 shift entry advances");
    for (int p = 2; p < 32; p++) begin
      pulse(1'b0);
      exp_out(ID[31-p], "R4 identifier bit");
    end
    for (int n = 0; n < 3; n++) begin
      pulse(1'b0);
      exp_out(1'b0, "R5 saturated position reads 0");
    end

    wr(cw(0, 0, 1, 0, 0));
    exp_out(1'b1, "R6 reset bit keeps buffer, position 0");
    pulse(1'b0);
    exp_out(1'b1, "R6 idle state does not advance");

    send_cmd(8'h87, 1'b0);
    exp_out(1'b0, "R9 page command clears buffer");
    exp_addr(24, "R9 page 3 address");

    for (int k = 0; k < 8; k++) begin
      send_cmd(OPS[k], 1'b0);
      exp_addr(24 + k, "R10 opcode offset address");
      exp_out(img_model(9'(24 + k))[7], "R10 loaded byte msb");
    end
    for (int b = 6; b >= 0; b--) begin
      pulse(1'b0);
      exp_out(img_model(9'd31)[b], "R10 loaded byte bit");
    end
    pulse(1'b0);
    exp_out(1'b0, "R10 bits below byte are 0");

    send_cmd(8'h55, 1'b0);
    exp_addr(24, "R10 offset 0 again");
    exp_out(img_model(9'd24)[7], "R10 offset 0 msb");
    send_cmd(8'h55, 1'b0);
    exp_out(1'b0, "R8 repeated command not run");

    shift_cmd(8'hAA, 1'b0);
    wr(cw(0, 1, 0, 0, 0));
    exp_out(1'b0, "R8 command drop without edge runs nothing");
    wr(cw(0, 0, 0, 0, 0));
    exp_addr(25, "R8 run on falling edge address");
    exp_out(img_model(9'd25)[7], "R8 run on falling edge data");

    send_cmd(8'h50, 1'b1);
    exp_addr(28, "R7 rising edges without command mode ignored");
    exp_out(img_model(9'd28)[7], "R7 noisy shift byte msb");

    send_cmd(8'h91, 1'b0);
    exp_addr(64, "R9 page 8 address");
    exp_out(1'b0, "R9 page 8 clear");
    send_cmd(8'hAA, 1'b0);
    exp_addr(65, "R10 page 8 offset 1");
    exp_out(img_model(9'd65)[7], "R10 page 8 offset 1 data");
    send_cmd(8'hFF, 1'b0);
    exp_addr(504, "R9 page 63 address");
    send_cmd(8'h54, 1'b0);
    exp_addr(506, "R10 page 63 offset 2");
    exp_out(1'b0, "R10 byte past image end");

    wr(cw(0, 0, 1, 0, 0));
    pulse(1'b1);
    exp_out(1'b1, "R3 identifier reload after commands");
    pulse(1'b0);
    exp_out(ID[30], "R3 second walk bit 30");
    wr(cw(0, 1, 0, 0, 0));
    wr(cw(0, 0, 1, 0, 0));
    exp_out(1'b1, "R6 reset applied before same-write edge");

    @(negedge clk); @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule